// File: doc/BRIEF.md
# TDM Slot-Masked Serial Transmitter

This block drives up to three serial data lines in a time-division multiplexed frame. All lines share one bit-clock enable and one frame sync. A host bus loads 24-bit words into per-channel holding registers, programs a 32-slot mask, and selects the word length, the bit alignment, the enabled channels and the frame length.

At each slot boundary, every channel either loads its held word into a shift register and sends it MSB first, or releases its line (output enable low) for the whole slot. The choice depends on three things: the mask bit of the new slot, the channel enable, and whether a null write is pending. Status and interrupt outputs report when the enabled holding registers have been drained, and whether a word had to be repeated.

Top module: `tdm_slot_tx`

Bus addresses are 0..2 for the channel data, 3 for the null register, 4 for the mask of slots 0..15, 5 for the mask of slots 16..31, 6 for control and 7 for status. The control fields are as follows.

| Bits | Field |
|------|-------|
| [1:0] | Word length code: 0 = 8, 1 = 12, 2 = 16, 3 = 24 bits |
| [2] | Alignment |
| [5:3] | Channel enables |
| [6] | Interrupt enable |
| [11:7] | Last slot number |

The status bits are as follows.

| Bit | Meaning |
|-----|---------|
| [0] | Combined empty |
| [1] | Underrun |
| [4:2] | Per-channel empty for channels 0..2 |

## Requirements
- R1: After reset, status reads 0x00001D, every sd_oe_o bit is low and irq_o is low.
- R2: Channel data addresses 0..2 are write-only and read as zero. A held word is loaded at an active slot boundary and sent MSB first, one bit per bit-clock tick. The first bit appears with the boundary tick, and the output changes only on ticks.
- R3: Control bits [1:0] select the word length: 0 = 8, 1 = 12, 2 = 16, 3 = 24 bits. A slot lasts exactly that many ticks.
- R4: When control bit [2] is clear, the first bit sent is data bit 23. When it is set, the first bit sent is data bit 15, and bits after bit 0 are sent as zero.
- R5: The masks at addresses 4 and 5 are read/write, and a read returns them in bits [15:0] with bits [23:16] zero. Mask bit n belongs to slot n. A set bit sends the word. A clear bit keeps the output enable low for the slot and moves no word.
- R6: A tick with fs_i high starts slot 0. Without fs_i, the slot after the last slot (control bits [11:7]) is slot 0.
- R7: A write to address 3 marks every enabled channel as serviced (not empty). The next slot then keeps all outputs disabled, sets no underrun, and leaves those channels empty again.
- R8: Each channel has its own empty flag, shown at status bit 2+n. Status bit 0 is set only when every enabled channel is empty. A disabled channel (control bit 3+n clear) never drives.
- R9: If an active slot finds its channel empty, the previous word is sent again and status bit 1 is set. The bit is cleared by a status read followed by a data write.
- R10: A status change caused by a write or a slot load becomes visible at the status address two clock cycles later.
- R11: irq_o is high exactly when the interrupt enable (control bit 6) is set and the delayed combined-empty status is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 24 | Write data |
| bus_rdata_o | output | 24 | Read data, zero when not reading |
| bclk_en_i | input | 1 | One-cycle bit-clock tick |
| fs_i | input | 1 | Frame sync, sampled on ticks |
| sd_o | output | NUM_CH | Serial data per channel |
| sd_oe_o | output | NUM_CH | Data output enable (low means high impedance) |
| irq_o | output | 1 | Transmit-empty interrupt request |

## Verification
The assertions assume three things about the inputs: the bit-clock enable is a single-cycle pulse, a bus read and a data write never fall in the same cycle, and bus writes never land in the cycle of a slot boundary. The stimulus keeps to these rules. It spaces ticks four clocks apart and issues bus accesses only in the idle cycles between ticks. It changes the word length or alignment only before a fresh frame sync, so the bit counter never sits beyond a newly shortened slot.

// File: rtl/tdm_slot_tx_pkg.sv
package tdm_slot_tx_pkg;
  localparam int unsigned BUS_W  = 24;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [2:0] {
    A_TX0 = 3'd0, A_TX1 = 3'd1, A_TX2 = 3'd2, A_NULL = 3'd3,
    A_MASK_LO = 3'd4, A_MASK_HI = 3'd5, A_CTRL = 3'd6, A_STAT = 3'd7
  } addr_e;

  typedef struct packed {
    logic [SLOT_W-1:0] last_slot;
    logic              irq_en;
    logic [2:0]        ch_en;
    logic              align_lo;
    logic [1:0]        wl_sel;
  } ctrl_t;

  function automatic logic [4:0] wl_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd8;
      2'd1:    return 5'd12;
      2'd2:    return 5'd16;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/tdm_slot_cnt.sv
module tdm_slot_cnt #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fs_i,
  input  logic [4:0]        wl_i,
  input  logic [SLOT_W-1:0] last_i,
  output logic              boundary_o,
  output logic [SLOT_W-1:0] next_slot_o
);
  logic [4:0]        bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              run_q;
  logic              last_bit;

  assign last_bit    = run_q && (bit_q == wl_i - 5'd1);
  assign boundary_o  = tick_i && (fs_i || last_bit);
  assign next_slot_o = fs_i ? '0 : ((slot_q == last_i) ? '0 : slot_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
    end else if (tick_i) begin
      if (boundary_o) begin
        bit_q  <= '0;
        slot_q <= next_slot_o;
        run_q  <= 1'b1;
      end else if (run_q) begin
        bit_q <= bit_q + 5'd1;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         send_i,
  input  logic         align_i,
  input  logic [W-1:0] word_i,
  output logic         sd_o,
  output logic         oe_o
);
  localparam int unsigned ALIGN_SH = W - 16;

  logic [W-1:0] sh_q;
  logic [W-1:0] aligned;

  // low alignment moves bit 15 to the top, zero-fill below
  assign aligned = align_i ? {word_i[W-ALIGN_SH-1:0], {ALIGN_SH{1'b0}}} : word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_o <= 1'b0;
    end else if (load_i) begin
      oe_o <= send_i;
      if (send_i) sh_q <= aligned;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign sd_o = sh_q[W-1];
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_tx_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              bclk_en_i,
  input  logic              fs_i,
  output logic [NUM_CH-1:0] sd_o,
  output logic [NUM_CH-1:0] sd_oe_o,
  output logic              irq_o
);
  localparam int unsigned MASK_W = 2 * HALF_W;
  localparam int unsigned STAT_W = 5;

  ctrl_t              ctrl_q;
  logic [MASK_W-1:0]  mask_q;
  logic [BUS_W-1:0]   hold_q [NUM_CH];
  logic [NUM_CH-1:0]  empty_q;
  logic [NUM_CH-1:0]  en_vec;
  logic [NUM_CH-1:0]  wr_tx;
  logic [NUM_CH-1:0]  send;
  logic               null_q, urun_q, arm_q;
  logic               wr_null, rd_stat, boundary, cur_mask_bit, comb_empty;
  logic [SLOT_W-1:0]  next_slot;
  logic [2:0]         empty3;
  logic [STAT_W-1:0]  stat_now, stat_d1, stat_d2;
  logic [BUS_W-1:0]   rd_mux;

  assign en_vec       = ctrl_q.ch_en[NUM_CH-1:0];
  assign wr_null      = bus_wr_i && (bus_addr_i == A_NULL);
  assign rd_stat      = bus_rd_i && (bus_addr_i == A_STAT);
  assign cur_mask_bit = mask_q[next_slot];

  tdm_slot_cnt #(.SLOT_W(SLOT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bclk_en_i),
    .fs_i        (fs_i),
    .wl_i        (wl_bits(ctrl_q.wl_sel)),
    .last_i      (ctrl_q.last_slot),
    .boundary_o  (boundary),
    .next_slot_o (next_slot)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign wr_tx[ch] = bus_wr_i && (bus_addr_i == 3'(ch));
    assign send[ch]  = en_vec[ch] & cur_mask_bit & ~null_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[ch]  <= '0;
        empty_q[ch] <= 1'b1;
      end else begin
        if (boundary && en_vec[ch] && (null_q || send[ch])) empty_q[ch] <= 1'b1;
        if (wr_tx[ch]) begin
          hold_q[ch]  <= bus_wdata_i;
          empty_q[ch] <= 1'b0;
        end else if (wr_null && en_vec[ch]) begin
          empty_q[ch] <= 1'b0;
        end
      end
    end

    tdm_tx_lane #(.W(BUS_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (boundary),
      .shift_i (bclk_en_i & ~boundary),
      .send_i  (send[ch]),
      .align_i (ctrl_q.align_lo),
      .word_i  (hold_q[ch]),
      .sd_o    (sd_o[ch]),
      .oe_o    (sd_oe_o[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      null_q <= 1'b0;
      urun_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (bus_wr_i && bus_addr_i == A_CTRL)    ctrl_q <= ctrl_t'(bus_wdata_i[$bits(ctrl_t)-1:0]);
      if (bus_wr_i && bus_addr_i == A_MASK_LO) mask_q[HALF_W-1:0] <= bus_wdata_i[HALF_W-1:0];
      if (bus_wr_i && bus_addr_i == A_MASK_HI) mask_q[MASK_W-1:HALF_W] <= bus_wdata_i[HALF_W-1:0];
      if (wr_null)       null_q <= 1'b1;
      else if (boundary) null_q <= 1'b0;
      if (rd_stat) arm_q <= 1'b1;
      if (|wr_tx && arm_q) begin
        urun_q <= 1'b0;
        arm_q  <= 1'b0;
      end
      if (boundary && |(send & empty_q)) urun_q <= 1'b1;
    end
  end

  always_comb begin
    empty3 = '1;
    for (int i = 0; i < NUM_CH; i++) empty3[i] = empty_q[i];
  end

  assign comb_empty = &(empty_q | ~en_vec);
  assign stat_now   = {empty3, urun_q, comb_empty};

  // status view lags internal state by two cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_d1 <= 5'b11101;
      stat_d2 <= 5'b11101;
    end else begin
      stat_d1 <= stat_now;
      stat_d2 <= stat_d1;
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_MASK_LO: rd_mux = {8'h00, mask_q[HALF_W-1:0]};
      A_MASK_HI: rd_mux = {8'h00, mask_q[MASK_W-1:HALF_W]};
      A_CTRL:    rd_mux = BUS_W'(ctrl_q);
      A_STAT:    rd_mux = BUS_W'(stat_d2);
      default:   rd_mux = '0;
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? rd_mux : '0;
  assign irq_o       = ctrl_q.irq_en & stat_d2[0];
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
  parameter int unsigned NUM_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bclk_en_i,
  input logic              bus_rd_i,
  input logic [2:0]        bus_addr_i,
  input logic [23:0]       bus_rdata_o,
  input logic [NUM_CH-1:0] sd_o,
  input logic [NUM_CH-1:0] sd_oe_o,
  input logic              boundary_i,
  input logic              mask_bit_i,
  input logic              null_i,
  input logic [NUM_CH-1:0] send_i,
  input logic [NUM_CH-1:0] empty_i,
  input logic              urun_i
);
  AST_OUT_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_en_i |=> $stable(sd_o) && $stable(sd_oe_o)); // R2

  AST_MASK_READ_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && (bus_addr_i == 3'd4 || bus_addr_i == 3'd5) |-> bus_rdata_o[23:16] == 8'h00); // R5

  AST_MASKED_SLOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && !mask_bit_i |=> sd_oe_o == '0); // R5

  AST_NULL_SLOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && null_i |=> sd_oe_o == '0); // R7

  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && |(send_i & empty_i) |=> urun_i); // R9
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bclk_en_i   (bclk_en_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .sd_o        (sd_o),
  .sd_oe_o     (sd_oe_o),
  .boundary_i  (boundary),
  .mask_bit_i  (cur_mask_bit),
  .null_i      (null_q),
  .send_i      (send),
  .empty_i     (empty_q),
  .urun_i      (urun_q)
);

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        bclk_en = 1'b0, fs = 1'b0;
  logic [2:0]  sd, sd_oe;
  logic        irq;
  logic        tick_d = 1'b0;
  int          checks = 0, fails = 0;

  typedef struct {
    logic [2:0] oe;
    logic [2:0] sd;
    string      req;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  always #5 clk = ~clk;

  tdm_slot_tx #(.NUM_CH(3)) i_tdm_slot_tx (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bclk_en_i(bclk_en), .fs_i(fs), .sd_o(sd), .sd_oe_o(sd_oe), .irq_o(irq)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop after each tick edge
  always @(posedge clk) tick_d <= bclk_en;
  always @(negedge clk) begin
    if (tick_d) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected tick", 24'h1, 24'h0);
      end else begin
        e = exp_q.pop_front();
        chk(e.req, {18'h0, sd_oe, sd & sd_oe}, {18'h0, e.oe, e.sd & e.oe});
      end
    end
  end

  task automatic bus_wr_t(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [23:0] exp, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(bit f, logic [2:0] oe, logic [2:0] sdv, string req);
    exp_t x;
    x.oe = oe; x.sd = sdv; x.req = req;
    exp_q.push_back(x);
    @(negedge clk);
    bclk_en = 1'b1; fs = f;
    @(negedge clk);
    bclk_en = 1'b0; fs = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic bitv(logic [23:0] w, bit al, int i);
    int p = (al ? 15 : 23) - i;
    return (p >= 0) ? w[p] : 1'b0;
  endfunction

  task automatic send_slot(bit f, logic [2:0] oe, logic [23:0] w0, logic [23:0] w1,
                           int wl, bit al, string req);
    for (int i = 0; i < wl; i++)
      tick(f && i == 0, oe, {1'b0, bitv(w1, al, i), bitv(w0, al, i)}, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 24'h1, 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(3'd7, 24'h00001D, "R1 status");
    chk("R1 oe", {21'h0, sd_oe}, 24'h0);
    chk("R1 irq", {23'h0, irq}, 24'h0);
    rd_chk(3'd0, 24'h0, "R2 tx write-only");
    // R5 mask read/write, upper byte zero
    bus_wr_t(3'd4, 24'hFF0005);
    bus_wr_t(3'd5, 24'h000000);
    rd_chk(3'd4, 24'h000005, "R5 mask lo");
    // ctrl: 8-bit, msb@23, ch0+ch1, last slot 3
    bus_wr_t(3'd6, 24'h000198);
    bus_wr_t(3'd0, 24'hC30000);
    rd_chk(3'd7, 24'h00001D, "R10 old status");
    rd_chk(3'd7, 24'h000018, "R10 new status");
    bus_wr_t(3'd1, 24'h5A0000);
    repeat (3) @(negedge clk);
    rd_chk(3'd7, 24'h000010, "R8 combined not empty");
    send_slot(1, 3'b011, 24'hC30000, 24'h5A0000, 8, 0, "R2 slot0 data");
    rd_chk(3'd7, 24'h00001D, "R8 all enabled empty");
    send_slot(0, 3'b000, 24'h0, 24'h0, 8, 0, "R5 masked slot1");
    send_slot(0, 3'b011, 24'hC30000, 24'h5A0000, 8, 0, "R9 resend slot2");
    rd_chk(3'd7, 24'h00001F, "R9 underrun set");
    bus_wr_t(3'd0, 24'h810000);
    bus_wr_t(3'd1, 24'h180000);
    repeat (3) @(negedge clk);
    rd_chk(3'd7, 24'h000010, "R9 underrun cleared");
    send_slot(0, 3'b000, 24'h0, 24'h0, 8, 0, "R5 masked slot3");
    send_slot(0, 3'b011, 24'h810000, 24'h180000, 8, 0, "R6 wrap to slot0");
    // R7 null slot
    bus_wr_t(3'd3, 24'h0);
    repeat (3) @(negedge clk);
    rd_chk(3'd7, 24'h000010, "R7 null serviced");
    send_slot(1, 3'b000, 24'h0, 24'h0, 8, 0, "R7 null slot off");
    repeat (3) @(negedge clk);
    rd_chk(3'd7, 24'h00001D, "R7 no underrun");
    // R4 low alignment
    bus_wr_t(3'd6, 24'h00019C);
    bus_wr_t(3'd0, 24'h00B700);
    bus_wr_t(3'd1, 24'hFF3C00);
    send_slot(1, 3'b011, 24'h00B700, 24'hFF3C00, 8, 1, "R4 msb@15");
    // R3 12-bit words
    bus_wr_t(3'd6, 24'h000199);
    bus_wr_t(3'd0, 24'hABC000);
    bus_wr_t(3'd1, 24'h123000);
    send_slot(1, 3'b011, 24'hABC000, 24'h123000, 12, 0, "R3 12-bit slot0");
    send_slot(0, 3'b000, 24'h0, 24'h0, 12, 0, "R3 12-bit slot1");
    send_slot(0, 3'b011, 24'hABC000, 24'h123000, 12, 0, "R3 12-bit slot2");
    // R11 interrupt
    repeat (3) @(negedge clk);
    bus_wr_t(3'd6, 24'h0001D9);
    chk("R11 irq on", {23'h0, irq}, 24'h1);
    bus_wr_t(3'd0, 24'h00ABCD);
    chk("R11 irq delayed", {23'h0, irq}, 24'h1);
    repeat (2) @(negedge clk);
    chk("R11 irq off", {23'h0, irq}, 24'h0);
    // R4 24-bit at msb@15, zero fill
    bus_wr_t(3'd6, 24'h00019F);
    bus_wr_t(3'd1, 24'h00F00F);
    send_slot(1, 3'b011, 24'h00ABCD, 24'h00F00F, 24, 1, "R4 24-bit zero fill");
    repeat (4) @(negedge clk);
    chk("R2 queue drained", 24'(exp_q.size()), 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule